// File: doc/BRIEF.md
# Expansion Chassis Self-Test Register Block

This block sits behind a small register window that a power-on self-test uses to probe an expansion chassis. It holds eight byte-wide registers selected by a 3-bit offset. Most registers are plain storage: what is written is what is read back. Two registers behave differently, so the test routine can tell a live unit from an empty slot.

Writing offset 4 copies the byte into registers 4, 5 and 6 in the same cycle. Reading offset 6 returns the current low byte of a 16-bit pair made of register 5 (high) and register 6 (low). On that same clock edge, the pair shifts left by one. A run of reads therefore walks a single bit upward through the pair.

The access interface is a plain strobe interface, not a stream. It has no valid/ready handshake and no back-pressure. An access completes in the cycle its strobe is high. Read data is combinational from the selected register and is valid for as long as the offset is held. Any side effect of an access lands on the next rising clock edge.

Top module: `exp_selftest_unit`

## Requirements
- R1: `rd_data` always shows the register selected by `addr` (offsets 0 to 7, eight 8-bit registers) as it stands before the coming clock edge.
- R2: While `rst_n` is low, register 6 holds 8'h01 and every other register holds 8'h00.
- R3: A cycle with `wr_en` high and `addr` = 4 loads `wr_data` into registers 4, 5 and 6 at that edge.
- R4: A cycle with `wr_en` high and `addr` other than 4 loads `wr_data` into the addressed register only. No strobe means no register changes.
- R5: A cycle with `rd_en` high, `wr_en` low and `addr` = 6 returns the old register 6 on `rd_data`. At that edge the 16-bit value {reg5, reg6} becomes its left shift by one: a zero enters bit 0 and old bit 15 is lost.
- R6: A read of any offset other than 6 leaves all eight registers unchanged.
- R7: Holding `rd_en` high at offset 6 for N cycles applies N single-bit shifts, one per edge.
- R8: When `rd_en` and `wr_en` are both high, the write is performed as in R3/R4 and no shift happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe, one read per high cycle |
| wr_en | input | 1 | Write strobe, wins over `rd_en` |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Selected register, combinational |

## Verification
The embedded assertions check four things on every cycle:
- the three-way fan-out of a write to offset 4;
- the exact shifted value of the pair after a lone read of offset 6;
- that a write wins over a simultaneous read;
- that register contents do not change under reads elsewhere or with no strobe.

Only the bench scenarios can show some other behaviours:
- the reset contents;
- the bit that walks up through the pair over sixteen or more back-to-back reads, including the carry from register 6 into register 5;
- the loss of bit 15;
- that `rd_data` shows the old byte rather than the shifted one.

The bench compares these against a behavioural model on every clock.

// File: rtl/exp_selftest_pkg.sv
package exp_selftest_pkg;
  localparam int unsigned EXP_DATA_W  = 8;
  localparam int unsigned EXP_ADDR_W  = 3;
  localparam int unsigned EXP_FAN_IDX = 4;  // write here fans out
  localparam int unsigned EXP_PAIR_HI = 5;  // high byte of shift pair
  localparam int unsigned EXP_PAIR_LO = 6;  // low byte, read triggers shift
  localparam int unsigned EXP_LO_INIT = 1;  // reset value of low byte
endpackage

// File: rtl/exp_st_decode.sv
module exp_st_decode
  import exp_selftest_pkg::*;
#(
  parameter int unsigned ADDR_W  = EXP_ADDR_W,
  parameter int unsigned FAN_IDX = EXP_FAN_IDX,
  parameter int unsigned PAIR_HI = EXP_PAIR_HI,
  parameter int unsigned PAIR_LO = EXP_PAIR_LO,
  localparam int unsigned NREG   = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [NREG-1:0]   load_en,
  output logic              shift_en
);
  localparam logic [ADDR_W-1:0] FAN_A = ADDR_W'(FAN_IDX);
  localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(PAIR_LO);

  always_comb begin
    load_en = '0;
    if (wr_en) begin
      load_en[addr] = 1'b1;
      if (addr == FAN_A) begin
        load_en[PAIR_HI] = 1'b1;
        load_en[PAIR_LO] = 1'b1;
      end
    end
  end

  // the write strobe has priority and suppresses the shift
  assign shift_en = rd_en && !wr_en && (addr == LO_A);
endmodule

// File: rtl/exp_st_bank.sv
module exp_st_bank
  import exp_selftest_pkg::*;
#(
  parameter int unsigned DATA_W  = EXP_DATA_W,
  parameter int unsigned ADDR_W  = EXP_ADDR_W,
  parameter int unsigned PAIR_HI = EXP_PAIR_HI,
  parameter int unsigned PAIR_LO = EXP_PAIR_LO,
  parameter int unsigned LO_INIT = EXP_LO_INIT,
  localparam int unsigned NREG   = 1 << ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREG-1:0]             load_en,
  input  logic                        shift_en,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NREG-1:0][DATA_W-1:0] regs_q
);
  logic [DATA_W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V =
      (i == PAIR_LO) ? DATA_W'(LO_INIT) : '0;
    logic [DATA_W-1:0] shift_v;

    if (i == PAIR_HI) begin : g_hi
      assign shift_v = {q[PAIR_HI][DATA_W-2:0], q[PAIR_LO][DATA_W-1]};
    end else if (i == PAIR_LO) begin : g_lo
      assign shift_v = {q[PAIR_LO][DATA_W-2:0], 1'b0};
    end else begin : g_plain
      assign shift_v = q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q[i] <= RST_V;
      else if (load_en[i])  q[i] <= wr_data;
      else if (shift_en)    q[i] <= shift_v;
    end

    assign regs_q[i] = q[i];
  end
endmodule

// File: rtl/exp_selftest_unit.sv
module exp_selftest_unit
  import exp_selftest_pkg::*;
#(
  parameter int unsigned DATA_W  = EXP_DATA_W,
  parameter int unsigned ADDR_W  = EXP_ADDR_W,
  parameter int unsigned FAN_IDX = EXP_FAN_IDX,
  parameter int unsigned PAIR_HI = EXP_PAIR_HI,
  parameter int unsigned PAIR_LO = EXP_PAIR_LO,
  parameter int unsigned LO_INIT = EXP_LO_INIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned NREG = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] FAN_A = ADDR_W'(FAN_IDX);
  localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(PAIR_LO);

  logic [NREG-1:0]             load_en;
  logic                        shift_en;
  logic [NREG-1:0][DATA_W-1:0] regs_q;

  exp_st_decode #(
    .ADDR_W(ADDR_W), .FAN_IDX(FAN_IDX), .PAIR_HI(PAIR_HI), .PAIR_LO(PAIR_LO)
  ) u_decode (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .load_en(load_en), .shift_en(shift_en)
  );

  exp_st_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAIR_HI(PAIR_HI),
    .PAIR_LO(PAIR_LO), .LO_INIT(LO_INIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
    .wr_data(wr_data), .regs_q(regs_q)
  );

  // read returns the pre-edge value; any shift lands on the edge
  assign rd_data = regs_q[addr];

  AST_FANOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == FAN_A) |=>
      (regs_q[FAN_IDX] == $past(wr_data)) && (regs_q[PAIR_HI] == $past(wr_data))
      && (regs_q[PAIR_LO] == $past(wr_data))); // R3

  AST_PAIR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == LO_A) |=>
      ({regs_q[PAIR_HI], regs_q[PAIR_LO]} ==
       {$past({regs_q[PAIR_HI], regs_q[PAIR_LO]}) << 1})); // R5

  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr != LO_A) |=> $stable(regs_q)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> $stable(regs_q)); // R4

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && addr != FAN_A) |=>
      (regs_q[$past(addr)] == $past(wr_data))); // R8
endmodule

// File: tb/exp_selftest_unit_bench.sv
module exp_selftest_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  int model [8];

  always #2.5 clk = ~clk;

  exp_selftest_unit u_exp_selftest_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) model[i] = 0;
    model[6] = 1;
  endtask

  // one access cycle: drive, compare rd_data mid-cycle, advance model
  task automatic cyc(input int a, input bit r, input bit w, input int d,
                     input string tag);
    int pair;
    @(negedge clk);
    addr = 3'(a); rd_en = r; wr_en = w; wr_data = 8'(d);
    #1 check(tag, int'(rd_data), model[a]);
    @(posedge clk);
    if (w) begin
      if (a == 4) begin model[4] = d; model[5] = d; model[6] = d; end
      else model[a] = d;
    end else if (r && a == 6) begin
      pair = ((model[5] << 8) | model[6]) << 1;
      model[5] = (pair >> 8) & 8'hff;
      model[6] = pair & 8'hff;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    // R2: contents while reset is held
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); addr = 3'(i);
      #1 check("R2 reset contents", int'(rd_data), model[i]);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2/R6: read back everything after reset, no side effects
    for (int i = 0; i < 8; i++) if (i != 6) cyc(i, 1, 0, 0, "R6 read other");
    for (int i = 0; i < 8; i++) cyc(i, 0, 0, 0, "R2 post-reset peek");

    // R5/R7: held read walks the bit through both bytes and off the top
    for (int i = 0; i < 18; i++) cyc(6, 1, 0, 0, "R7 held read walk");
    cyc(5, 0, 0, 0, "R5 high byte after walk");
    cyc(6, 0, 0, 0, "R5 low byte after walk");

    // R4: individual writes touch only their register
    for (int i = 0; i < 8; i++) if (i != 4) cyc(i, 0, 1, 8'h10 + i * 8'h11, "R4 single write");
    for (int i = 0; i < 8; i++) cyc(i, 0, 0, 0, "R4 readback");

    // R3: fan-out write, then R1 readback
    cyc(4, 0, 1, 8'hC3, "R3 fan write");
    for (int i = 0; i < 8; i++) cyc(i, 0, 0, 0, "R3 readback");

    // R5: old byte returned, carry between bytes
    for (int i = 0; i < 3; i++) cyc(6, 1, 0, 0, "R5 read shifts");
    cyc(5, 0, 0, 0, "R5 carry into high");

    // R8: write wins over read
    cyc(6, 1, 1, 8'h81, "R8 rd+wr at 6");
    cyc(6, 0, 0, 0, "R8 no shift");
    cyc(5, 0, 0, 0, "R8 high untouched");
    cyc(4, 1, 1, 8'h5A, "R8 rd+wr at 4");
    for (int i = 4; i < 7; i++) cyc(i, 0, 0, 0, "R8 fan readback");

    // R1: mixed traffic compared every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0);
      cyc(lfsr & 7, (lfsr >> 3) & 1, ((lfsr >> 4) & 3) == 0, (lfsr >> 6) & 8'hff,
          "R1 mixed traffic");
    end
    idle();

    // R2: reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0; model_reset();
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) cyc(i, 0, 0, 0, "R2 re-reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule